// File: doc/BRIEF.md
# Serial Maximum-and-Difference Unit

This block takes a frame of unsigned samples, locates the largest one, and then reports how far each sample sits below it. Area is kept small by time-sharing the arithmetic. A single magnitude comparator walks the stored frame one sample per cycle to find the peak. A single subtractor then streams out one difference per cycle.

A frame enters in one cycle as a packed vector together with a load strobe. While the unit works, it raises a busy flag. Each result appears with a valid flag and the position of the sample it belongs to. A one-cycle done pulse closes the frame. The position of the peak is available on its own port while the differences stream out.

Top module: `maxdiff_serial`

## Requirements
- R1: When load_i is high in a clock cycle with busy_o low, the frame on samples_i is captured at that edge, and busy_o is high from the next cycle. Sample k occupies bits [k*9 +: 9] of samples_i.
- R2: The unit spends 15 cycles comparing after the load edge. The first difference is valid in the 16th cycle after the load edge, and out_valid_o then stays high for exactly 16 consecutive cycles.
- R3: Every valid out_diff_o equals the frame maximum minus the sample named by out_idx_o, as an unsigned 9-bit value that is never negative.
- R4: The differences are emitted in index order: out_idx_o is 0 on the first valid cycle and rises by one on each following valid cycle, up to 15.
- R5: max_idx_o gives the lowest index holding the largest value. A later equal value does not displace an earlier one. max_idx_o is stable during every valid cycle of a frame.
- R6: The difference reported at index max_idx_o is zero.
- R7: done_o is high for exactly one cycle, in the cycle right after the one carrying index 15. busy_o is low in that cycle and stays low until the next accepted load.
- R8: A load_i pulse while busy_o is high has no effect: the running frame's outputs, timing and max_idx_o stay those of the frame captured first.
- R9: A synchronous active-high rst_i clears busy_o, out_valid_o and done_o in the next cycle, abandoning any frame in progress. A later load then starts a clean frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Frame capture strobe, honoured only when idle |
| samples_i | input | 144 | Sixteen packed 9-bit unsigned samples, sample k at bits [k*9 +: 9] |
| busy_o | output | 1 | High while a frame is being processed |
| out_valid_o | output | 1 | out_diff_o and out_idx_o carry a result |
| out_idx_o | output | 4 | Index of the sample the current difference belongs to |
| out_diff_o | output | 9 | Frame maximum minus the indexed sample |
| done_o | output | 1 | One-cycle pulse after the last difference |
| max_idx_o | output | 4 | Lowest index holding the frame maximum |

## Verification
The bench builds the block with its defaults: sixteen samples of nine bits. At that size the sample counter uses every code of its four bits, so the end of each phase lands on the counter's all-ones value. The samples also reach both ends of their range (0 and 511), so the largest possible difference is exercised. Frames with every sample equal, with the peak first or last, and with repeated peaks test the tie rule. A reset in the middle of a frame and load strobes that arrive during busy or right at done test the phase control at its edges.

// File: rtl/maxdiff_pkg.sv
package maxdiff_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SCAN = 2'd1,
      PH_DIFF = 2'd2,
      PH_FIN  = 2'd3
   } phase_e;
endpackage

// File: rtl/md_sample_bank.sv
module md_sample_bank #(
   parameter int NUM_SAMPLES = 16,
   parameter int DATA_W      = 9,
   parameter int IDX_W       = $clog2(NUM_SAMPLES)
) (
   input  logic                          clk_i,
   input  logic                          capture_i,
   input  logic [NUM_SAMPLES*DATA_W-1:0] frame_i,
   input  logic [IDX_W-1:0]              rd_sel_i,
   output logic [DATA_W-1:0]             rd_data_o
);
   logic [DATA_W-1:0] bank_q [NUM_SAMPLES];

   for (genvar g = 0; g < NUM_SAMPLES; g++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (capture_i) begin
            bank_q[g] <= frame_i[g*DATA_W +: DATA_W];
         end
      end
   end

   assign rd_data_o = bank_q[rd_sel_i];
endmodule

// File: rtl/md_max_scan.sv
module md_max_scan #(
   parameter int DATA_W = 9,
   parameter int IDX_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              seed_i,
   input  logic [DATA_W-1:0] seed_val_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] cand_i,
   input  logic [IDX_W-1:0]  cand_idx_i,
   output logic [DATA_W-1:0] max_o,
   output logic [IDX_W-1:0]  max_idx_o
);
   logic take_cand;

   assign take_cand = step_i && (cand_i > max_o);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         max_o     <= '0;
         max_idx_o <= '0;
      end else if (seed_i) begin
         max_o     <= seed_val_i;
         max_idx_o <= '0;
      end else if (take_cand) begin
         max_o     <= cand_i;
         max_idx_o <= cand_idx_i;
      end
   end

   // R5
   acc_monotone_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && !seed_i |=> max_o >= $past(cand_i) && max_o >= $past(max_o));

   // R5
   tie_keeps_idx_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && !seed_i && cand_i == max_o |=> $stable(max_idx_o));
endmodule

// File: rtl/md_diff_unit.sv
module md_diff_unit #(
   parameter int DATA_W = 9,
   parameter int IDX_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] max_i,
   input  logic [DATA_W-1:0] samp_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              valid_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [DATA_W-1:0] diff_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_o <= 1'b0;
         idx_o   <= '0;
         diff_o  <= '0;
      end else begin
         valid_o <= en_i;
         if (en_i) begin
            idx_o  <= idx_i;
            diff_o <= max_i - samp_i;
         end
      end
   end

   // R3
   no_underflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |-> samp_i <= max_i);
endmodule

// File: rtl/maxdiff_serial.sv
module maxdiff_serial #(
   parameter int NUM_SAMPLES = 16,
   parameter int DATA_W      = 9,
   parameter int IDX_W       = $clog2(NUM_SAMPLES)
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic                          load_i,
   input  logic [NUM_SAMPLES*DATA_W-1:0] samples_i,
   output logic                          busy_o,
   output logic                          out_valid_o,
   output logic [IDX_W-1:0]              out_idx_o,
   output logic [DATA_W-1:0]             out_diff_o,
   output logic                          done_o,
   output logic [IDX_W-1:0]              max_idx_o
);
   import maxdiff_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SAMPLES - 1);

   if (NUM_SAMPLES < 2) begin : g_bad_count
      $error("maxdiff_serial: NUM_SAMPLES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("maxdiff_serial: DATA_W must be positive");
   end
   if (IDX_W < $clog2(NUM_SAMPLES)) begin : g_bad_idx
      $error("maxdiff_serial: IDX_W too narrow for NUM_SAMPLES");
   end

   phase_e            phase_q;
   logic [IDX_W-1:0]  cnt_q;
   logic              done_q;
   logic              accept;
   logic              scan_step;
   logic              diff_step;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] max_val;

   assign accept    = (phase_q == PH_IDLE) && load_i;
   assign scan_step = (phase_q == PH_SCAN);
   assign diff_step = (phase_q == PH_DIFF);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (load_i) begin
                  phase_q <= PH_SCAN;
                  cnt_q   <= IDX_W'(1);
               end
            end
            PH_SCAN: begin
               if (cnt_q == LAST_IDX) begin
                  phase_q <= PH_DIFF;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + IDX_W'(1);
               end
            end
            PH_DIFF: begin
               if (cnt_q == LAST_IDX) begin
                  phase_q <= PH_FIN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + IDX_W'(1);
               end
            end
            PH_FIN: begin
               done_q  <= 1'b1;
               phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   md_sample_bank #(
      .NUM_SAMPLES(NUM_SAMPLES),
      .DATA_W     (DATA_W),
      .IDX_W      (IDX_W)
   ) u_bank (
      .clk_i    (clk_i),
      .capture_i(accept),
      .frame_i  (samples_i),
      .rd_sel_i (cnt_q),
      .rd_data_o(rd_data)
   );

   md_max_scan #(
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u_scan (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .seed_i    (accept),
      .seed_val_i(samples_i[DATA_W-1:0]),
      .step_i    (scan_step),
      .cand_i    (rd_data),
      .cand_idx_i(cnt_q),
      .max_o     (max_val),
      .max_idx_o (max_idx_o)
   );

   md_diff_unit #(
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u_diff (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (diff_step),
      .max_i  (max_val),
      .samp_i (rd_data),
      .idx_i  (cnt_q),
      .valid_o(out_valid_o),
      .idx_o  (out_idx_o),
      .diff_o (out_diff_o)
   );

   assign busy_o = (phase_q != PH_IDLE);
   assign done_o = done_q;

   // R4
   idx_sequence_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      out_valid_o && out_idx_o != '0 |-> $past(out_valid_o) && out_idx_o == $past(out_idx_o) + IDX_W'(1));

   // R6
   zero_at_peak_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      out_valid_o && out_idx_o == max_idx_o |-> out_diff_o == '0);

   // R5
   peak_idx_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      out_valid_o && $past(out_valid_o) |-> $stable(max_idx_o));

   // R7
   done_after_last_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> $past(out_valid_o) && $past(out_idx_o) == LAST_IDX && !busy_o);

   // R8
   busy_load_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      busy_o && load_i |=> !(phase_q == PH_SCAN && cnt_q == IDX_W'(1)));

   // R9
   reset_clears_chk: assert property (@(posedge clk_i)
      $past(rst_i) |-> !busy_o && !out_valid_o && !done_o);
endmodule

// File: tb/maxdiff_serial_tb.sv
module maxdiff_serial_tb;
   localparam int N  = 16;
   localparam int W  = 9;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          load;
   logic [N*W-1:0] samples;
   logic          busy;
   logic          out_valid;
   logic [IW-1:0] out_idx;
   logic [W-1:0]  out_diff;
   logic          done;
   logic [IW-1:0] max_idx;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   maxdiff_serial #(.NUM_SAMPLES(N), .DATA_W(W), .IDX_W(IW)) u_dut (
      .clk_i      (clk),
      .rst_i      (rst),
      .load_i     (load),
      .samples_i  (samples),
      .busy_o     (busy),
      .out_valid_o(out_valid),
      .out_idx_o  (out_idx),
      .out_diff_o (out_diff),
      .done_o     (done),
      .max_idx_o  (max_idx)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
         finish_run();
      end
   end

   // Run one frame; optionally inject a load during busy (R8) or reset at a given step (R9).
   task automatic run_frame(input int s[N], input int inject_at, input int reset_at);
      logic [N*W-1:0] vec;
      int mx;
      int mi;
      mx = -1;
      mi = 0;
      for (int k = 0; k < N; k++) begin
         vec[k*W +: W] = W'(s[k]);
         if (s[k] > mx) begin
            mx = s[k];
            mi = k;
         end
      end
      samples = vec;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      for (int n = 1; n <= 33; n++) begin
         if (n == inject_at) begin
            samples = ~vec;
            load = 1'b1;
         end
         if (n == reset_at) rst = 1'b1;
         @(negedge clk);
         load = 1'b0;
         if (reset_at > 0 && n >= reset_at) begin
            rst = 1'b0;
            check(!busy && !out_valid && !done, "R9 reset clears flags",
                  {busy, out_valid, done}, 0);
            @(negedge clk);
            return;
         end
         check(busy == (n <= 31), "R1/R7 busy", busy, n <= 31);
         check(out_valid == (n >= 16 && n <= 31), "R2 valid window", out_valid,
               n >= 16 && n <= 31);
         check(done == (n == 32), "R7 done pulse", done, n == 32);
         if (n >= 16 && n <= 31) begin
            check(out_idx == IW'(n - 16), "R4 index order", out_idx, n - 16);
            check(out_diff == W'(mx - s[n-16]), "R3 difference", out_diff, mx - s[n-16]);
            check(max_idx == IW'(mi), "R5 peak index", max_idx, mi);
            if (n - 16 == mi) check(out_diff == '0, "R6 zero at peak", out_diff, 0);
         end
      end
   endtask

   initial begin
      int s[N];
      rst = 1'b1;
      load = 1'b0;
      samples = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!busy && !out_valid && !done, "R9 reset state", {busy, out_valid, done}, 0);

      for (int k = 0; k < N; k++) s[k] = (k * 73 + 5) % 512;
      run_frame(s, 0, 0);
      for (int k = 0; k < N; k++) s[k] = 200;
      run_frame(s, 0, 0);
      for (int k = 0; k < N; k++) s[k] = k * 30;
      run_frame(s, 0, 0);
      for (int k = 0; k < N; k++) s[k] = (k % 2 == 0) ? 511 : 0;
      run_frame(s, 0, 0);
      for (int k = 0; k < N; k++) s[k] = (k == 7 || k == 12) ? 300 : 0;
      run_frame(s, 0, 0);
      // R8: loads during compare and subtract phases are ignored
      for (int k = 0; k < N; k++) s[k] = (k * 29 + 100) % 400;
      run_frame(s, 5, 0);
      run_frame(s, 20, 0);
      run_frame(s, 31, 0);
      // R9: reset mid-frame, then a clean frame
      for (int k = 0; k < N; k++) s[k] = 511 - k;
      run_frame(s, 0, 20);
      run_frame(s, 0, 0);
      @(negedge clk);
      check(!busy && !done, "R7 idle after done", {busy, done}, 0);
      finish_run();
   end
endmodule